// File: doc/BRIEF.md
# PCI Memory Read Command and Burst Selector

This block belongs to the read path of a PCI bus-master DMA engine. For each read request it picks one of three PCI memory read commands: plain Memory Read, Memory Read Line or Memory Read Multiple. It also picks the number of 32-bit data phases that the read should cover. The request carries the current byte address, the number of bytes still to move and a flag that marks instruction (opcode) fetches. The configuration inputs are sampled with each request. They give three enables, the programmed cache line size in dwords, and a maximum burst code with one extension bit.

Read Multiple is chosen only when the configuration allows it, the read is not an opcode fetch, the line size is legal, the address sits on a line boundary and at least two full lines remain. The burst then covers the largest whole number of lines that fit in both the remaining data and the burst cap. When those conditions fail and line reads are enabled with a legal line size, a Memory Read Line reaches up to the next line boundary. In every other case a plain Memory Read is issued. Requests are accepted over a valid/ready handshake, and the result is held in a registered response slot until the consumer takes it. Only single address phases are produced.

Top module: `pci_rd_cmd_sel`

## Requirements
- R1: The command codes are 4'b0110 (Memory Read), 4'b1110 (Memory Read Line) and 4'b1100 (Memory Read Multiple), and no other code is ever presented (in particular no dual address code). After reset rsp_valid is 0. When a request is accepted at a clock edge, rsp_valid is 1 after that edge and carries that request's result.
- R2: Memory Read Multiple is issued only when both cfg_line_en and cfg_mult_en are 1.
- R3: A request with req_fetch = 1 never yields Memory Read Multiple.
- R4: cfg_line_dw is legal only when it is 2, 4, 8, 16, 32, 64 or 128 and no larger than the burst cap. With an illegal size, the result is Memory Read with the R10 length.
- R5: The burst cap in dwords is 2^min(k+1, 8), where k = {cfg_burst_ext, cfg_burst_code} is read as a 4-bit number.
- R6: Memory Read Multiple requires that the remaining dwords be at least twice cfg_line_dw. Exactly twice is enough.
- R7: Memory Read Multiple requires req_addr to be a multiple of 4*cfg_line_dw bytes.
- R8: For Memory Read Multiple, rsp_len = min(cap, remaining dwords rounded down to a multiple of cfg_line_dw).
- R9: When Memory Read Multiple does not apply but cfg_line_en, cfg_rdline_en and a legal size all hold, the result is Memory Read Line. Its rsp_len = min(dwords from the address to the next line boundary, remaining dwords, cap). The dword address is req_addr[31:2].
- R10: Otherwise the result is Memory Read with rsp_len = min(cap, remaining dwords). Remaining dwords are ceil(req_bytes/4), so 0 bytes gives a length of 0.
- R11: req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is 1 and rsp_ready is 0, the response holds steady and any new request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| cfg_line_en | input | 1 | Cache line size in use |
| cfg_mult_en | input | 1 | Read Multiple allowed |
| cfg_rdline_en | input | 1 | Read Line allowed |
| req_fetch | input | 1 | Request is an opcode fetch |
| cfg_line_dw | input | 8 | Cache line size in dwords |
| cfg_burst_code | input | 3 | Burst cap code |
| cfg_burst_ext | input | 1 | Burst cap extension bit |
| req_addr | input | 32 | Byte address of the read |
| req_bytes | input | 16 | Bytes still to transfer |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_cmd | output | 4 | PCI command code |
| rsp_len | output | 9 | Burst length in data phases |

## Verification
Directed cases start from one request that meets every Read Multiple condition, then break one condition at a time: an enable, the fetch flag, an odd or oversized line size, one dword of misalignment, and one dword short of two lines. Each case shows which guard demotes the command to Read Line or to plain Memory Read. Boundary values cover exactly two lines, a zero and a sub-dword byte count, and the largest line with the extended cap, which separate the rounding and capping rules. Random requests with mostly legal line sizes and aligned addresses are scored against a bench model. On some of them the consumer stalls while a different request is offered, to show that the slot holds and ignores the newcomer.

// File: rtl/pci_rdsel_pkg.sv
package pci_rdsel_pkg;

   typedef enum logic [3:0] {
      CMD_MEM_RD      = 4'b0110,
      CMD_MEM_RD_LINE = 4'b1110,
      CMD_MEM_RD_MULT = 4'b1100
   } pci_rd_cmd_e;

endpackage

// File: rtl/pci_rdsel_burst_cap.sv
module pci_rdsel_burst_cap #(
   parameter int CODE_W  = 3,
   parameter int MAX_LOG = 8,
   parameter bit EXT_EN  = 1'b1,
   localparam int LOGW   = $clog2(MAX_LOG + 1),
   localparam int LEN_W  = MAX_LOG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic              ext,
   output logic [LOGW-1:0]   cap_log,
   output logic [LEN_W-1:0]  cap_dw
);

   logic [CODE_W:0] k;

   generate
      if (EXT_EN) begin : g_ext
         assign k = {ext, code};
      end else begin : g_noext
         logic unused_ext;
         assign unused_ext = ext;
         assign k = {1'b0, code};
      end
   endgenerate

   always_comb begin
      int kk;
      kk = int'(k) + 1;
      if (kk > MAX_LOG) kk = MAX_LOG;
      cap_log = LOGW'(kk);
   end

   assign cap_dw = LEN_W'(1) << cap_log;

   assert_cap_pow2_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cap_dw) == 1 && cap_dw >= LEN_W'(2));

endmodule

// File: rtl/pci_rdsel_line_chk.sv
module pci_rdsel_line_chk #(
   parameter int CLS_W        = 8,
   parameter int LINE_MIN_LOG = 1,
   parameter int LINE_MAX_LOG = 7,
   parameter int LOGW         = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CLS_W-1:0] line_dw,
   input  logic [LOGW-1:0]  cap_log,
   output logic             legal,
   output logic [LOGW-1:0]  line_log
);

   generate
      if (LINE_MAX_LOG >= CLS_W) begin : g_bad_w
         $error("line size field too narrow for largest legal line");
      end
   endgenerate

   logic [LINE_MAX_LOG:LINE_MIN_LOG] hit;

   genvar gi;
   generate
      for (gi = LINE_MIN_LOG; gi <= LINE_MAX_LOG; gi++) begin : g_hit
         assign hit[gi] = (line_dw == CLS_W'(1 << gi));
      end
   endgenerate

   always_comb begin
      line_log = '0;
      for (int i = LINE_MIN_LOG; i <= LINE_MAX_LOG; i++) begin
         if (hit[i]) line_log = LOGW'(i);
      end
   end

   assign legal = (|hit) && (line_log <= cap_log);

   assert_legal_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
      legal |-> ($countones(line_dw) == 1 &&
                 line_dw >= CLS_W'(1 << LINE_MIN_LOG) &&
                 line_dw <= CLS_W'(1 << LINE_MAX_LOG)));

endmodule

// File: rtl/pci_rdsel_decide.sv
module pci_rdsel_decide
   import pci_rdsel_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int REM_W   = 16,
   parameter int MAX_LOG = 8,
   localparam int LOGW   = $clog2(MAX_LOG + 1),
   localparam int LEN_W  = MAX_LOG + 1,
   localparam int CW     = REM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_en,
   input  logic              mult_en,
   input  logic              rdline_en,
   input  logic              fetch,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REM_W-1:0]  bytes_left,
   input  logic              legal,
   input  logic [LOGW-1:0]   line_log,
   input  logic [LEN_W-1:0]  cap_dw,
   output pci_rd_cmd_e       cmd,
   output logic [LEN_W-1:0]  len
);

   generate
      if (ADDR_W < CW + 2) begin : g_bad_addr
         $error("address too narrow for remaining-count width");
      end
      if (CW < LEN_W) begin : g_bad_len
         $error("remaining-count width below length width");
      end
   endgenerate

   function automatic logic [CW-1:0] mn(input logic [CW-1:0] a, input logic [CW-1:0] b);
      return (a < b) ? a : b;
   endfunction

   logic [REM_W+1:0] bytes_rnd;
   logic [CW-1:0]    rem_dw, line_w, mask, off, to_bnd, cap_w;
   logic             aligned, mult_ok, line_ok;
   logic [CW-1:0]    mult_len, line_len, plain_len;

   assign bytes_rnd = {2'b00, bytes_left} + (REM_W+2)'(3);
   assign rem_dw    = {1'b0, bytes_rnd[REM_W+1:2]};
   assign line_w    = CW'(1) << line_log;
   assign mask      = line_w - CW'(1);
   assign off       = addr[CW+1:2] & mask;
   assign to_bnd    = line_w - off;
   assign cap_w     = {{(CW-LEN_W){1'b0}}, cap_dw};
   assign aligned   = (off == '0) && (addr[1:0] == 2'b00);

   assign mult_ok = line_en && mult_en && !fetch && legal && aligned &&
                    (rem_dw >= (line_w << 1));
   assign line_ok = line_en && rdline_en && legal;

   assign mult_len  = mn(cap_w, rem_dw & ~mask);
   assign line_len  = mn(mn(to_bnd, rem_dw), cap_w);
   assign plain_len = mn(cap_w, rem_dw);

   always_comb begin
      if (mult_ok) begin
         cmd = CMD_MEM_RD_MULT;
         len = mult_len[LEN_W-1:0];
      end else if (line_ok) begin
         cmd = CMD_MEM_RD_LINE;
         len = line_len[LEN_W-1:0];
      end else begin
         cmd = CMD_MEM_RD;
         len = plain_len[LEN_W-1:0];
      end
   end

   assert_mult_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MEM_RD_MULT) |-> (line_en && mult_en));
   assert_fetch_no_mult_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |-> (cmd != CMD_MEM_RD_MULT));
   assert_mult_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MEM_RD_MULT) |-> (len <= cap_dw && CW'(len) >= line_w));
   assert_len_capped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      len <= cap_dw);

endmodule

// File: rtl/pci_rdsel_out_reg.sv
module pci_rdsel_out_reg
   import pci_rdsel_pkg::*;
#(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  pci_rd_cmd_e      in_cmd,
   input  logic [LEN_W-1:0] in_len,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [3:0]       out_cmd,
   output logic [LEN_W-1:0] out_len
);

   logic accept;

   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_cmd   <= 4'(CMD_MEM_RD);
         out_len   <= '0;
      end else begin
         if (accept) begin
            out_valid <= 1'b1;
            out_cmd   <= 4'(in_cmd);
            out_len   <= in_len;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   assert_accept_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);
   assert_cmd_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_cmd == 4'b0110 || out_cmd == 4'b1110 || out_cmd == 4'b1100));
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_cmd) && $stable(out_len)));

endmodule

// File: rtl/pci_rd_cmd_sel.sv
module pci_rd_cmd_sel
   import pci_rdsel_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int REM_W        = 16,
   parameter int CLS_W        = 8,
   parameter int CODE_W       = 3,
   parameter int MAX_LOG      = 8,
   parameter int LINE_MIN_LOG = 1,
   parameter int LINE_MAX_LOG = 7,
   parameter bit EXT_EN       = 1'b1,
   localparam int LOGW        = $clog2(MAX_LOG + 1),
   localparam int LEN_W       = MAX_LOG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              cfg_line_en,
   input  logic              cfg_mult_en,
   input  logic              cfg_rdline_en,
   input  logic              req_fetch,
   input  logic [CLS_W-1:0]  cfg_line_dw,
   input  logic [CODE_W-1:0] cfg_burst_code,
   input  logic              cfg_burst_ext,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [REM_W-1:0]  req_bytes,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [3:0]        rsp_cmd,
   output logic [LEN_W-1:0]  rsp_len
);

   generate
      if (MAX_LOG < LINE_MAX_LOG) begin : g_bad_cap
         $error("burst cap cannot reach the largest legal line");
      end
   endgenerate

   logic [LOGW-1:0]  cap_log, line_log;
   logic [LEN_W-1:0] cap_dw, nxt_len;
   logic             legal;
   pci_rd_cmd_e      nxt_cmd;

   pci_rdsel_burst_cap #(
      .CODE_W (CODE_W), .MAX_LOG (MAX_LOG), .EXT_EN (EXT_EN)
   ) u_cap (
      .clk (clk), .rst_n (rst_n), .code (cfg_burst_code), .ext (cfg_burst_ext),
      .cap_log (cap_log), .cap_dw (cap_dw)
   );

   pci_rdsel_line_chk #(
      .CLS_W (CLS_W), .LINE_MIN_LOG (LINE_MIN_LOG),
      .LINE_MAX_LOG (LINE_MAX_LOG), .LOGW (LOGW)
   ) u_line (
      .clk (clk), .rst_n (rst_n), .line_dw (cfg_line_dw), .cap_log (cap_log),
      .legal (legal), .line_log (line_log)
   );

   pci_rdsel_decide #(
      .ADDR_W (ADDR_W), .REM_W (REM_W), .MAX_LOG (MAX_LOG)
   ) u_dec (
      .clk (clk), .rst_n (rst_n), .line_en (cfg_line_en), .mult_en (cfg_mult_en),
      .rdline_en (cfg_rdline_en), .fetch (req_fetch), .addr (req_addr),
      .bytes_left (req_bytes), .legal (legal), .line_log (line_log),
      .cap_dw (cap_dw), .cmd (nxt_cmd), .len (nxt_len)
   );

   pci_rdsel_out_reg #(
      .LEN_W (LEN_W)
   ) u_out (
      .clk (clk), .rst_n (rst_n), .in_valid (req_valid), .in_ready (req_ready),
      .in_cmd (nxt_cmd), .in_len (nxt_len), .out_valid (rsp_valid),
      .out_ready (rsp_ready), .out_cmd (rsp_cmd), .out_len (rsp_len)
   );

endmodule

// File: tb/tb_pci_rd_cmd_sel.sv
`timescale 1ns/1ps
module tb_pci_rd_cmd_sel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic        cfg_line_en = 1'b0, cfg_mult_en = 1'b0, cfg_rdline_en = 1'b0;
   logic        req_fetch = 1'b0;
   logic [7:0]  cfg_line_dw = '0;
   logic [2:0]  cfg_burst_code = '0;
   logic        cfg_burst_ext = 1'b0;
   logic [31:0] req_addr = '0;
   logic [15:0] req_bytes = '0;
   logic        rsp_valid, rsp_ready = 1'b0;
   logic [3:0]  rsp_cmd;
   logic [8:0]  rsp_len;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pci_rd_cmd_sel dut (
      .clk, .rst_n, .req_valid, .req_ready, .cfg_line_en, .cfg_mult_en,
      .cfg_rdline_en, .req_fetch, .cfg_line_dw, .cfg_burst_code, .cfg_burst_ext,
      .req_addr, .req_bytes, .rsp_valid, .rsp_ready, .rsp_cmd, .rsp_len
   );

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // Bench model written from the requirements
   function automatic void model(output int cmd, output int len);
      int k, cap, rem, line, off;
      bit legal, mult;
      k    = {cfg_burst_ext, cfg_burst_code};
      cap  = 1 << imin(k + 1, 8);
      rem  = (int'(req_bytes) + 3) / 4;
      line = cfg_line_dw;
      legal = 1'b0;
      for (int s = 1; s <= 7; s++) if (line == (1 << s)) legal = 1'b1;
      if (line > cap) legal = 1'b0;
      off  = legal ? int'(req_addr[31:2]) % line : 0;
      mult = cfg_line_en && cfg_mult_en && !req_fetch && legal &&
             (req_addr % (4 * line) == 0) && rem >= 2 * line;
      if (mult) begin
         cmd = 4'b1100; len = imin(cap, (rem / line) * line);
      end else if (cfg_line_en && cfg_rdline_en && legal) begin
         cmd = 4'b1110; len = imin(imin(line - off, rem), cap);
      end else begin
         cmd = 4'b0110; len = imin(cap, rem);
      end
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input bit le, input bit me, input bit re, input bit f,
                          input int line, input int code, input bit ext,
                          input int addr, input int bytes);
      cfg_line_en = le; cfg_mult_en = me; cfg_rdline_en = re; req_fetch = f;
      cfg_line_dw = 8'(line); cfg_burst_code = 3'(code); cfg_burst_ext = ext;
      req_addr = 32'(addr); req_bytes = 16'(bytes);
   endtask

   // inputs already set; issues one request and scores it
   task automatic do_req(input string tag, input bit stall);
      int ecmd, elen;
      string t;
      @(negedge clk);
      model(ecmd, elen);
      t = tag;
      if (t == "") t = (ecmd == 4'b1100) ? "R8" : (ecmd == 4'b1110) ? "R9" : "R10";
      req_valid = 1'b1; rsp_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1", int'(rsp_valid), 1, "valid after accept");
      check(t, int'(rsp_cmd), ecmd, "cmd");
      check(t, int'(rsp_len), elen, "len");
      if (stall) begin
         check("R11", int'(req_ready), 0, "ready while stalled");
         cfg_line_dw = 8'($urandom_range(0, 255));
         req_bytes = 16'($urandom);
         req_fetch = ~req_fetch;
         req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         check("R11", int'(rsp_valid), 1, "valid held");
         check("R11", int'(rsp_cmd), ecmd, "cmd held");
         check("R11", int'(rsp_len), elen, "len held");
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check("R11", int'(rsp_valid), 0, "valid cleared after take");
   endtask

   initial begin
      void'($urandom(32'h5eed_0c1a));
      repeat (3) @(negedge clk);
      check("R1", int'(rsp_valid), 0, "reset valid");
      check("R11", int'(req_ready), 1, "reset ready");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(rsp_valid), 0, "valid idle after reset");

      // cap 16 dwords, line 8 dwords, 25 dwords left, aligned
      set_cfg(1, 1, 1, 0, 8, 3, 0, 32'h100, 100); do_req("R8", 1'b0);
      set_cfg(1, 0, 1, 0, 8, 3, 0, 32'h100, 100); do_req("R2", 1'b0);
      set_cfg(0, 1, 1, 0, 8, 3, 0, 32'h100, 100); do_req("R2", 1'b0);
      set_cfg(1, 1, 1, 1, 8, 3, 0, 32'h100, 100); do_req("R3", 1'b0);
      set_cfg(1, 1, 1, 0, 12, 3, 0, 32'h100, 100); do_req("R4", 1'b0);
      set_cfg(1, 1, 1, 0, 32, 3, 0, 32'h100, 200); do_req("R4", 1'b0);
      set_cfg(1, 1, 1, 0, 8, 3, 0, 32'h100, 60); do_req("R6", 1'b0);
      set_cfg(1, 1, 1, 0, 8, 3, 0, 32'h100, 64); do_req("R6", 1'b0);
      set_cfg(1, 1, 1, 0, 8, 3, 0, 32'h104, 100); do_req("R7", 1'b0);
      set_cfg(1, 1, 1, 0, 128, 7, 1, 32'h1000, 4096); do_req("R5", 1'b0);
      set_cfg(1, 1, 1, 0, 128, 6, 0, 32'h1000, 4096); do_req("R5", 1'b0);
      set_cfg(0, 0, 0, 0, 0, 0, 1, 32'h0, 65535); do_req("R5", 1'b0);
      set_cfg(0, 0, 0, 0, 0, 7, 0, 32'h0, 5); do_req("R10", 1'b0);
      set_cfg(0, 0, 0, 0, 0, 7, 0, 32'h0, 0); do_req("R10", 1'b0);
      set_cfg(1, 1, 1, 0, 8, 3, 0, 32'h100, 100); do_req("R11", 1'b1);

      for (int i = 0; i < 1500; i++) begin
         int line, a;
         line = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 255)
                                            : (1 << $urandom_range(1, 7));
         a = $urandom;
         if ($urandom_range(0, 2) != 0 && line != 0) a = a & ~(4 * line - 1);
         set_cfg(1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0),
                 line, $urandom_range(0, 7), 1'($urandom), a,
                 ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535)
                                             : $urandom_range(0, 2048));
         do_req("", ($urandom_range(0, 3) == 0));
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule